// File: doc/BRIEF.md
# Guarded Shared Service Request Register

This block is a 16-bit word of service requests that two agents share: a host processor and a channel engine. The word is split into eight 2-bit fields, one per channel. Channel `i` sits at bits `[2i+1:2i]`. A nonzero field tells the engine that the channel needs service. The engine acknowledges a finished service by clearing the field back to zero.

The host always writes a whole word, but a write guard drops every field written as `00`. Only the engine may produce the value `00`. Because of the guard, the host can post a request to one channel by writing that channel's code and zeros everywhere else. It needs no read-modify-write sequence, and it cannot overwrite a field that the engine is changing at the same time.

Each field is a small state machine with four states. They are named after the field codes:

- `SR_DONE` (00): service complete.
- `SR_INIT` (01): initialization request.
- `SR_REQ_A` (10): host request A.
- `SR_REQ_B` (11): host request B.

The state machine has three transitions:

- **host-post**: any state goes to the written code when the host writes a nonzero value to the field.
- **engine-clear**: any state goes to `SR_DONE` when the engine signals completion and no host post occurs in that cycle.
- **hold**: otherwise the state is unchanged.

Top module: `svreq_shared_reg`

## Requirements
- R1: After reset, `rd_data` is 0x0000 and every `svc_pending` bit is 0.
- R2: When `host_wr_en` is high, a field of `host_wr_data` holding 01, 10 or 11 is stored in that channel's field. The new value appears on `rd_data` after the next rising clock edge.
- R3: When `host_wr_en` is high, a field of `host_wr_data` holding 00 leaves that channel's field at its previous value, provided the engine does not clear it in the same cycle.
- R4: A host write that carries a code in one field and zeros in all other fields changes only that one channel's field.
- R5: When `eng_done[i]` is high and the host posts nothing nonzero to field `i`, field `i` becomes 00 after the next edge. The other fields are unaffected.
- R6: If the host writes a nonzero code to field `i` in the same cycle that `eng_done[i]` is high, the host code is stored.
- R7: If the host writes 00 to field `i` in the same cycle that `eng_done[i]` is high, field `i` becomes 00.
- R8: `svc_pending[i]` is 1 exactly when field `i` (bits `[2i+1:2i]` of `rd_data`) is nonzero.
- R9: With `host_wr_en` low and `eng_done` all zero, the register holds its value across cycles, so reading has no side effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr_en | input | 1 | Host write strobe for a whole word |
| host_wr_data | input | 16 | Host write word; channel i in bits [2i+1:2i] |
| eng_done | input | 8 | Per-channel completion from the engine |
| rd_data | output | 16 | Current register contents |
| svc_pending | output | 8 | Per-channel nonzero-field flag |

## Verification
The hardest case to reach is a collision, where the host's word and the engine's completion hit the same field in one cycle. Both the nonzero-wins outcome and the zero-is-dropped outcome must be shown. The bench first loads every channel with every legal code. It then sweeps each host code against engine completion on that same channel, and also on a neighbouring channel. A long pseudo-random run with dense simultaneous writes and clears follows, compared against an arithmetic model of the word.

// File: rtl/svreq_pkg.sv
package svreq_pkg;
    localparam int unsigned FIELD_W = 2;

    typedef enum logic [FIELD_W-1:0] {
        SR_DONE  = 2'b00,
        SR_INIT  = 2'b01,
        SR_REQ_A = 2'b10,
        SR_REQ_B = 2'b11
    } sr_code_e;
endpackage

// File: rtl/svreq_guard.sv
module svreq_guard #(
    parameter int unsigned NUM_CH  = 8,
    parameter int unsigned FIELD_W = 2,
    localparam int unsigned WORD_W = NUM_CH * FIELD_W
) (
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic [NUM_CH-1:0] accept
);
    // A field is accepted only when the host strobe is high and the written
    // value is one that the host is allowed to produce (nonzero).
    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        assign accept[g] = wr_en && (wr_data[g*FIELD_W +: FIELD_W] != '0);
    end
endmodule

// File: rtl/svreq_field.sv
module svreq_field
    import svreq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               post,
    input  logic [FIELD_W-1:0] post_code,
    input  logic               clr,
    output logic [FIELD_W-1:0] code_q,
    output logic               pending
);
    sr_code_e state_q, state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SR_DONE;
        else        state_q <= state_d;
    end

    // Next state: host-post beats engine-clear, otherwise hold
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SR_DONE: begin
                if (post) state_d = sr_code_e'(post_code);
            end
            SR_INIT, SR_REQ_A, SR_REQ_B: begin
                if (post)     state_d = sr_code_e'(post_code);
                else if (clr) state_d = SR_DONE;
            end
            default: state_d = SR_DONE;
        endcase
    end

    // Outputs
    always_comb begin
        code_q = state_q;
        unique case (state_q)
            SR_DONE:                     pending = 1'b0;
            SR_INIT, SR_REQ_A, SR_REQ_B: pending = 1'b1;
            default:                     pending = 1'b0;
        endcase
    end

    a_r2_post_stored: assert property (@(posedge clk) disable iff (!rst_n)
        post |=> code_q == $past(post_code));

    a_r5_clear_done: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !post) |=> code_q == '0);

    a_r3_hold_no_post: assert property (@(posedge clk) disable iff (!rst_n)
        (!post && !clr) |=> $stable(code_q));

    a_r8_pending_state: assert property (@(posedge clk) disable iff (!rst_n)
        $past(post) |-> pending);
endmodule

// File: rtl/svreq_shared_reg.sv
module svreq_shared_reg
    import svreq_pkg::*;
#(
    parameter int unsigned NUM_CH = 8,
    localparam int unsigned WORD_W = NUM_CH * FIELD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr_en,
    input  logic [WORD_W-1:0] host_wr_data,
    input  logic [NUM_CH-1:0] eng_done,
    output logic [WORD_W-1:0] rd_data,
    output logic [NUM_CH-1:0] svc_pending
);
    logic [NUM_CH-1:0] accept;

    svreq_guard #(.NUM_CH(NUM_CH), .FIELD_W(FIELD_W)) u_guard (
        .wr_en   (host_wr_en),
        .wr_data (host_wr_data),
        .accept  (accept)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_field
        svreq_field u_field (
            .clk       (clk),
            .rst_n     (rst_n),
            .post      (accept[g]),
            .post_code (host_wr_data[g*FIELD_W +: FIELD_W]),
            .clr       (eng_done[g]),
            .code_q    (rd_data[g*FIELD_W +: FIELD_W]),
            .pending   (svc_pending[g])
        );

        // R6: a nonzero host write colliding with completion keeps the host code
        a_r6_host_wins: assert property (@(posedge clk) disable iff (!rst_n)
            (host_wr_en && eng_done[g] && host_wr_data[g*FIELD_W +: FIELD_W] != '0)
            |=> rd_data[g*FIELD_W +: FIELD_W] == $past(host_wr_data[g*FIELD_W +: FIELD_W]));

        // R7: a zero host write colliding with completion leaves the field cleared
        a_r7_zero_yields: assert property (@(posedge clk) disable iff (!rst_n)
            (host_wr_en && eng_done[g] && host_wr_data[g*FIELD_W +: FIELD_W] == '0)
            |=> rd_data[g*FIELD_W +: FIELD_W] == '0);
    end
endmodule

// File: tb/sim_svreq_shared_reg.sv
module sim_svreq_shared_reg;
    localparam int NUM_CH = 8;
    localparam int WORD_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              host_wr_en = 1'b0;
    logic [WORD_W-1:0] host_wr_data = '0;
    logic [NUM_CH-1:0] eng_done = '0;
    logic [WORD_W-1:0] rd_data;
    logic [NUM_CH-1:0] svc_pending;

    int checks = 0;
    int errors = 0;
    logic [WORD_W-1:0] model = '0;
    logic [31:0] lfsr = 32'h1ACE_B00C;

    always #4 clk = ~clk;  // 125 MHz

    svreq_shared_reg u0 (
        .clk(clk), .rst_n(rst_n), .host_wr_en(host_wr_en),
        .host_wr_data(host_wr_data), .eng_done(eng_done),
        .rd_data(rd_data), .svc_pending(svc_pending)
    );

    function automatic logic [WORD_W-1:0] next_word(
        input logic [WORD_W-1:0] cur, input logic we,
        input logic [WORD_W-1:0] d, input logic [NUM_CH-1:0] dn);
        logic [WORD_W-1:0] r = cur;
        for (int i = 0; i < NUM_CH; i++) begin
            if (we && d[2*i +: 2] != 2'b00) r[2*i +: 2] = d[2*i +: 2];
            else if (dn[i])                 r[2*i +: 2] = 2'b00;
        end
        return r;
    endfunction

    task automatic check_word(input string req);
        logic [NUM_CH-1:0] pexp;
        for (int i = 0; i < NUM_CH; i++) pexp[i] = (model[2*i +: 2] != 2'b00);
        checks++;
        if (rd_data !== model) begin
            errors++;
            $display("FAIL %s rd_data actual %h expected %h", req, rd_data, model);
        end
        checks++;
        if (svc_pending !== pexp) begin
            errors++;
            $display("FAIL R8 svc_pending actual %b expected %b (%s)", svc_pending, pexp, req);
        end
    endtask

    task automatic step(input logic we, input logic [WORD_W-1:0] d,
                        input logic [NUM_CH-1:0] dn, input string req);
        @(negedge clk);
        host_wr_en = we; host_wr_data = d; eng_done = dn;
        model = next_word(model, we, d, dn);
        @(posedge clk);
        #2;
        host_wr_en = 1'b0; host_wr_data = '0; eng_done = '0;
        check_word(req);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #3;
        check_word("R1");  // reset state
        #20 rst_n = 1'b1;
        check_word("R1");

        // R2/R4: single-field posts of every legal code to every channel
        for (int ch = 0; ch < NUM_CH; ch++)
            for (int c = 1; c < 4; c++)
                step(1'b1, WORD_W'(c) << (2*ch), '0, "R2_R4");

        // R3: an all-zero write changes nothing; R9: idle cycles hold the word
        step(1'b1, '0, '0, "R3");
        for (int k = 0; k < 4; k++) step(1'b0, '0, '0, "R9");

        // R5: clear each channel in turn, then refill
        for (int ch = 0; ch < NUM_CH; ch++) begin
            step(1'b0, '0, NUM_CH'(1) << ch, "R5");
            step(1'b1, WORD_W'(2'b10) << (2*ch), '0, "R2");
        end

        // R6/R7: collisions on the same channel and on a neighbour
        for (int ch = 0; ch < NUM_CH; ch++)
            for (int c = 0; c < 4; c++)
                for (int init = 1; init < 4; init++) begin
                    step(1'b1, WORD_W'(init) << (2*ch), '0, "R2");
                    step(1'b1, WORD_W'(c) << (2*ch), NUM_CH'(1) << ch,
                         (c == 0) ? "R7" : "R6");
                    step(1'b1, WORD_W'(c) << (2*ch), NUM_CH'(1) << ((ch + 1) % NUM_CH),
                         "R4_R5");
                end

        // R10 (mixed): pseudo-random dense traffic
        for (int k = 0; k < 3000; k++) begin
            lfsr = lfsr ^ (lfsr << 13);
            lfsr = lfsr ^ (lfsr >> 17);
            lfsr = lfsr ^ (lfsr << 5);
            step(lfsr[31], lfsr[15:0], lfsr[23:16] & lfsr[30:23], "R2_R3_R5_R6_R7");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule